// File: doc/BRIEF.md
# Two-Input Bridge Command Sequencer

This block sits between two command lines from a controller and the gate drivers of a single full H-bridge. It resynchronizes the two lines, turns their combination into enables for the two high-side and two low-side switches, and owns the bridge-wide operating state. That state covers driving in either direction, braking by shorting the motor through both low-side switches, and coasting with every switch open.

When both lines stay low long enough, the block drops into a low-power sleep state. On the first command that follows, it wakes up but keeps the bridge dark for a fixed settling interval before any drive takes effect.

Three single-bit protection flags gate the bridge. An overcurrent event is held in a sticky latch that only a wake-up from sleep or a reset can clear. Over-temperature and low supply flags switch the bridge off only for as long as they are present.

Top module: `hbridge_cmd_seq`

## Requirements
- R1: With cmd_a=1 and cmd_b=0 (forward) only hs_a and ls_b are on; with cmd_a=0 and cmd_b=1 (reverse) only ls_a and hs_b are on.
- R2: With cmd_a=1 and cmd_b=1 (brake) only ls_a and ls_b are on.
- R3: With cmd_a=0 and cmd_b=0 (coast) all four enables are off.
- R4: asleep rises after IDLE_CYCLES consecutive clocks in which both synchronized commands are low. Any high synchronized command restarts that count from zero.
- R5: After asleep falls because a command went high, all enables stay off for WAKE_CYCLES clocks, and then follow the commands.
- R6: An overcurrent flag turns all enables off at once and sets ovc_held. ovc_held and the disable persist after the flag drops, and are cleared only by an exit from sleep or by reset.
- R7: While hot_flag is high all enables are off; when it drops, drive resumes with no latching.
- R8: While lowv_flag is high all enables are off.
- R9: hs_a and ls_a are never on together, and hs_b and ls_b are never on together.
- R10: Each command passes through two flip-flops. A change reaches the enables after the second rising clock edge and not after the first.
- R11: After reset all enables are off, and asleep and ovc_held are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset (supply reset) |
| cmd_a | input | 1 | command line for half-bridge A |
| cmd_b | input | 1 | command line for half-bridge B |
| ovc_flag | input | 1 | overcurrent comparator flag |
| hot_flag | input | 1 | over-temperature flag |
| lowv_flag | input | 1 | supply undervoltage flag |
| hs_a | output | 1 | high-side enable, half-bridge A |
| ls_a | output | 1 | low-side enable, half-bridge A |
| hs_b | output | 1 | high-side enable, half-bridge B |
| ls_b | output | 1 | low-side enable, half-bridge B |
| asleep | output | 1 | low-power sleep state active |
| ovc_held | output | 1 | overcurrent fault latched |
| bridge_off | output | 1 | global disable currently in force |

## Verification
The bench builds the block with IDLE_CYCLES=6 and WAKE_CYCLES=3 instead of the 1 ms and 200 µs defaults. At these values the sleep entry, the restart of the idle count and the wake-up blanking window can each be checked on the exact clock edge. The bench sweeps every command pair against every combination of the temperature and supply flags. It then walks the overcurrent latch through its set, hold and clear paths, with the clear happening through a short sleep cycle.

// File: rtl/hbridge_cmd_seq.sv
module hbridge_cmd_seq #(
  parameter int IDLE_CYCLES = 100000,
  parameter int WAKE_CYCLES = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_a,
  input  logic cmd_b,
  input  logic ovc_flag,
  input  logic hot_flag,
  input  logic lowv_flag,
  output logic hs_a,
  output logic ls_a,
  output logic hs_b,
  output logic ls_b,
  output logic asleep,
  output logic ovc_held,
  output logic bridge_off
);
  localparam int IW = (IDLE_CYCLES > 1) ? $clog2(IDLE_CYCLES) : 1;
  localparam int WW = $clog2(WAKE_CYCLES + 1);

  logic [1:0]    sync_a, sync_b;
  logic [IW-1:0] idle_cnt;
  logic [WW-1:0] wake_cnt;
  logic          a_s, b_s, active, wake_up;

  assign a_s     = sync_a[1];
  assign b_s     = sync_b[1];
  assign active  = a_s | b_s;
  assign wake_up = asleep & active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
    end else begin
      sync_a <= {sync_a[0], cmd_a};
      sync_b <= {sync_b[0], cmd_b};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      asleep   <= 1'b0;
    end else if (active) begin
      idle_cnt <= '0;
      asleep   <= 1'b0;
    end else if (!asleep) begin
      if (idle_cnt == IW'(IDLE_CYCLES - 1)) asleep <= 1'b1;
      else idle_cnt <= idle_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_cnt <= '0;
    else if (wake_up) wake_cnt <= WW'(WAKE_CYCLES);
    else if (wake_cnt != '0) wake_cnt <= wake_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovc_held <= 1'b0;
    else if (wake_up) ovc_held <= 1'b0;
    else if (ovc_flag) ovc_held <= 1'b1;
  end

  assign bridge_off = ovc_flag | ovc_held | hot_flag | lowv_flag | asleep | (wake_cnt != '0);

  assign hs_a = !bridge_off &  a_s & !b_s;
  assign ls_a = !bridge_off & !a_s &  b_s | !bridge_off & a_s & b_s;
  assign hs_b = !bridge_off & !a_s &  b_s;
  assign ls_b = !bridge_off &  a_s;

  a_r9_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_a && ls_a) && !(hs_b && ls_b));

  a_r8_r7_flags_block: assert property (@(posedge clk) disable iff (!rst_n)
    (hot_flag || lowv_flag || ovc_flag) |-> !(hs_a || ls_a || hs_b || ls_b));

  a_r6_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovc_held && !wake_up) |=> ovc_held);

  a_r5_wake_blank: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> bridge_off);

  a_r4_sleep_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(!active));
endmodule

// File: tb/test_hbridge_cmd_seq.sv
module test_hbridge_cmd_seq;
  localparam int IDLE = 6;
  localparam int WAKE = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_a = 1'b0, cmd_b = 1'b0;
  logic ovc_flag = 1'b0, hot_flag = 1'b0, lowv_flag = 1'b0;
  logic hs_a, ls_a, hs_b, ls_b, asleep, ovc_held, bridge_off;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hbridge_cmd_seq #(.IDLE_CYCLES(IDLE), .WAKE_CYCLES(WAKE)) i_hbridge_cmd_seq (
    .clk(clk), .rst_n(rst_n), .cmd_a(cmd_a), .cmd_b(cmd_b),
    .ovc_flag(ovc_flag), .hot_flag(hot_flag), .lowv_flag(lowv_flag),
    .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b),
    .asleep(asleep), .ovc_held(ovc_held), .bridge_off(bridge_off));

  function automatic logic [3:0] want(input logic a, input logic b);
    if (a && !b) return 4'b1001;
    if (!a && b) return 4'b0110;
    if (a && b)  return 4'b0101;
    return 4'b0000;
  endfunction

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] en();
    return {hs_a, ls_a, hs_b, ls_b};
  endfunction

  initial begin
    @(negedge clk); @(negedge clk);
    chk({en(), 1'b0, 1'b0, 1'b0} == 7'b0 ? 4'd0 : 4'd1, 4'd0, "R11 enables during reset");
    rst_n = 1'b1;
    ticks(1);
    chk({asleep, ovc_held, 2'b00}, 4'b0000, "R11 status after reset");
    chk(en(), 4'b0000, "R11 enables after reset");

    // sweep every command pair against temperature and supply flags
    for (int m = 0; m < 16; m++) begin
      cmd_a = m[0]; cmd_b = m[1]; hot_flag = m[2]; lowv_flag = m[3];
      ticks(2);
      chk(en(), (m[2] | m[3]) ? 4'b0000 : want(m[0], m[1]),
          m[3] ? "R8 lowv" : m[2] ? "R7 hot" :
          (m[1:0] == 2'b11) ? "R2 brake" : (m[1:0] == 2'b00) ? "R3 coast" : "R1 drive");
      chk({3'b000, i_hbridge_cmd_seq.hs_a & i_hbridge_cmd_seq.ls_a | hs_b & ls_b}, 4'b0000, "R9 half-bridge exclusive");
    end
    hot_flag = 1'b0; lowv_flag = 1'b0;
    ticks(1);
    chk(en(), want(1'b1, 1'b1), "R7 resumes after hot drops");

    // synchronizer latency
    cmd_a = 1'b1; cmd_b = 1'b0;
    ticks(1);
    chk(en(), want(1'b1, 1'b1), "R10 not after first edge");
    ticks(1);
    chk(en(), want(1'b1, 1'b0), "R10 after second edge");

    // idle count restarts on a short pulse
    cmd_a = 1'b0;
    ticks(2 + IDLE - 2);
    cmd_b = 1'b1;
    ticks(1);
    cmd_b = 1'b0;
    ticks(2 + IDLE - 1);
    chk({asleep, 3'b000}, 4'b0000, "R4 count restarted by pulse");
    ticks(1);
    chk({asleep, 3'b000}, 4'b1000, "R4 asleep after idle count");
    ticks(IDLE + 1);
    chk(en(), 4'b0000, "R3 coast while asleep");

    // wake-up blanking
    cmd_a = 1'b1;
    ticks(2 + WAKE);
    chk({asleep, en()[3:1]}, 4'b0000, "R5 still blanked");
    ticks(1);
    chk(en(), want(1'b1, 1'b0), "R5 drive after wake delay");

    // overcurrent latch
    ovc_flag = 1'b1;
    #1;
    chk(en(), 4'b0000, "R6 immediate disable");
    ticks(1);
    ovc_flag = 1'b0;
    ticks(3);
    chk({ovc_held, en()[3:1]}, 4'b1000, "R6 latch holds");
    cmd_a = 1'b1; cmd_b = 1'b1;
    ticks(4);
    chk({ovc_held, en()[3:1]}, 4'b1000, "R6 command change does not clear");
    cmd_a = 1'b0; cmd_b = 1'b0;
    ticks(2 + IDLE + 2);
    chk({asleep, ovc_held, 2'b00}, 4'b1100, "R6 held through sleep");
    cmd_b = 1'b1;
    ticks(3);
    chk({asleep, ovc_held, 2'b00}, 4'b0000, "R6 cleared on wake");
    ticks(WAKE);
    chk(en(), want(1'b0, 1'b1), "R6 R5 drive after clear");

    // reset also clears the latch
    ovc_flag = 1'b1;
    ticks(1);
    ovc_flag = 1'b0;
    rst_n = 1'b0;
    ticks(1);
    rst_n = 1'b1;
    ticks(2);
    chk({ovc_held, 3'b000}, 4'b0000, "R6 R11 reset clears latch");
    chk(en(), want(1'b0, 1'b1), "R11 drive after reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule